// File: doc/BRIEF.md
# Progress-Indicating Moore Sequence Detector

This block watches a one-bit serial stream, taking one bit per clock edge, and raises a flag when the last three bits received were 0, then 1, then 1. It is a Moore machine, so every output comes from the registered state alone. A detection therefore appears in the cycle after the last matching bit is sampled, and the current input never has a combinational path to any output.

The state register uses a thermometer code and drives a 3-bit progress output directly. That output shows how much of the pattern has been matched so far, so it can light a row of three indicators. The detect flag is the top bit of that code. A parameter chooses whether a finished match may share its trailing bits with the next match, or whether the machine restarts after each detection. For this pattern the two choices give the same output stream.

If the state register ever holds one of the four unused codes, the machine returns to the idle state on the next clock edge.

Top module: `seqdet_progress`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `match_level` = 000 and `found` = 0.
- R2: `found` is 1 in the cycle that follows the rising edge which sampled the final 1 of the bit sequence 0, 1, 1. In every other cycle `found` is 0.
- R3: `match_level` shows the matched length as a thermometer code. It is 000 when nothing is matched, 001 after a trailing 0, 011 after a trailing 0 then 1, and 111 after the full sequence 0, 1, 1. No other value ever appears.
- R4: From the complete state (111), a 0 moves the machine to 001 and a 1 moves it to 000.
- R5: `found` equals bit 2 of `match_level`. It stays high for exactly one cycle per detection.
- R6: With OVERLAP = 1 and with OVERLAP = 0, the block produces the same output stream for the same input stream. Back-to-back patterns such as 0,1,1,0,1,1 are detected twice in both modes.
- R7: A run of 1s from idle keeps `match_level` at 000. A run of 0s keeps it at 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial data bit |
| match_level | output | 3 | Thermometer count of matched pattern bits |
| found | output | 1 | High for one cycle after the pattern completes |

## Verification
The assertions check on every cycle that:
- the progress code is always one of the four legal values;
- a detection can only follow the two-matched state fed with a 1;
- a detection never lasts two cycles;
- the exits from the complete state follow the input;
- reset clears the state.

Only the bench scenarios can show the rest:
- the full output stream matches a history-based reference model over long random streams with a reset in the middle;
- the two overlap modes produce identical streams;
- runs of equal bits and back-to-back patterns give the right counts.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int PAT_LEN = 3;
    localparam int LEVEL_W = PAT_LEN;

    typedef enum logic [LEVEL_W-1:0] {
        ST_NONE = 3'b000,
        ST_ONE  = 3'b001,
        ST_TWO  = 3'b011,
        ST_ALL  = 3'b111
    } level_e;

    function automatic logic is_legal(logic [LEVEL_W-1:0] s);
        return (s == ST_NONE) || (s == ST_ONE) || (s == ST_TWO) || (s == ST_ALL);
    endfunction

    // one step of the 0-1-1 matcher; unknown codes fall back to idle
    function automatic level_e advance(logic [LEVEL_W-1:0] s, logic b);
        level_e r;
        case (s)
            ST_NONE: r = b ? ST_NONE : ST_ONE;
            ST_ONE:  r = b ? ST_TWO  : ST_ONE;
            ST_TWO:  r = b ? ST_ALL  : ST_ONE;
            ST_ALL:  r = b ? ST_NONE : ST_ONE;
            default: r = ST_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seqdet_step.sv
module seqdet_step
    import seqdet_pkg::*;
#(
    parameter bit OVERLAP = 1'b1
) (
    input  logic [LEVEL_W-1:0] cur,
    input  logic               bit_in,
    output level_e             nxt
);

    generate
        if (OVERLAP) begin : g_overlap
            // trailing bits of a finished match carry into the next one
            assign nxt = advance(cur, bit_in);
        end else begin : g_restart
            // after a detection the machine behaves as if it were idle
            assign nxt = (cur == ST_ALL) ? advance(ST_NONE, bit_in)
                                         : advance(cur, bit_in);
        end
    endgenerate

    // unused codes must return to idle
    always_comb begin
        if (!is_legal(cur)) begin
            illegal_recover_chk: assert (nxt == ST_NONE);
        end
    end

endmodule

// File: rtl/seqdet_level_reg.sv
module seqdet_level_reg
    import seqdet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  level_e d,
    output level_e q
);

    always_ff @(posedge clk) begin
        if (rst) q <= ST_NONE;
        else     q <= d;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (q == ST_NONE));

endmodule

// File: rtl/seqdet_progress.sv
module seqdet_progress
    import seqdet_pkg::*;
#(
    parameter bit OVERLAP = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               serial_in,
    output logic [LEVEL_W-1:0] match_level,
    output logic               found
);

    level_e cur_q;
    level_e nxt_d;

    seqdet_step #(.OVERLAP(OVERLAP)) u_step (
        .cur    (cur_q),
        .bit_in (serial_in),
        .nxt    (nxt_d)
    );

    seqdet_level_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_d),
        .q   (cur_q)
    );

    assign match_level = cur_q;
    assign found       = cur_q[LEVEL_W-1];

    // R3
    level_thermo_chk: assert property (@(posedge clk) disable iff (rst)
        is_legal(match_level));

    // R2
    found_after_pair_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> ($past(match_level) == ST_TWO) && $past(serial_in));

    // R5
    found_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        found |=> !found);

    // R4
    exit_complete_chk: assert property (@(posedge clk) disable iff (rst)
        (match_level == ST_ALL) |=>
            (match_level == ($past(serial_in) ? ST_NONE : ST_ONE)));

endmodule

// File: tb/seqdet_progress_test.sv
`timescale 1ns/1ps
module seqdet_progress_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_in = 1'b0;
    logic [2:0] match_level, lvl_nov;
    logic       found, found_nov;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference history
    logic [2:0] hist;
    int         nbits;

    always #2 clk = ~clk;

    seqdet_progress #(.OVERLAP(1'b1)) uut (
        .clk(clk), .rst(rst), .serial_in(serial_in),
        .match_level(match_level), .found(found)
    );

    seqdet_progress #(.OVERLAP(1'b0)) uut_nov (
        .clk(clk), .rst(rst), .serial_in(serial_in),
        .match_level(lvl_nov), .found(found_nov)
    );

    function automatic logic [2:0] exp_level(logic [2:0] h, int n);
        if (n >= 3 && h == 3'b011)      return 3'b111;
        if (n >= 2 && h[1:0] == 2'b01)  return 3'b011;
        if (n >= 1 && h[0] == 1'b0)     return 3'b001;
        return 3'b000;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        hist = 3'b000;
        nbits = 0;
        check("R1 level", {1'b0, match_level}, 4'b0000);
        check("R1 found", {3'b000, found}, 4'b0000);
    endtask

    // drive at negedge, sampled at posedge, checked at next negedge
    task automatic send(logic b, string tag);
        logic [2:0] e;
        serial_in = b;
        @(negedge clk);
        hist = {hist[1:0], b};
        nbits++;
        e = exp_level(hist, nbits);
        check(tag, {1'b0, match_level}, {1'b0, e});
        check("R2 found", {3'b000, found}, {3'b000, e == 3'b111});
        check("R5 found=bit2", {3'b000, found}, {3'b000, match_level[2]});
        check("R6 modes", {found_nov, lvl_nov}, {found, match_level});
    endtask

    task automatic send_exp(logic b, logic [2:0] want, string tag);
        send(b, tag);
        check(tag, {1'b0, match_level}, {1'b0, want});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20220201));
        do_reset();

        // R3 climbing thermometer
        send_exp(1'b0, 3'b001, "R3 one");
        send_exp(1'b1, 3'b011, "R3 two");
        send_exp(1'b1, 3'b111, "R3 all");
        // R4 exit with 0, then re-complete, exit with 1
        send_exp(1'b0, 3'b001, "R4 exit0");
        send_exp(1'b1, 3'b011, "R3 two");
        send_exp(1'b1, 3'b111, "R6 second detect");
        send_exp(1'b1, 3'b000, "R4 exit1");
        // R7 runs
        for (int i = 0; i < 5; i++) send_exp(1'b1, 3'b000, "R7 ones");
        for (int i = 0; i < 5; i++) send_exp(1'b0, 3'b001, "R7 zeros");
        // two-matched then 0
        send_exp(1'b1, 3'b011, "R3 two");
        send_exp(1'b0, 3'b001, "R3 fallback");

        // random streams with mid-stream resets
        for (int i = 0; i < 3000; i++) begin
            if (i % 1000 == 500) do_reset();
            send(1'(($urandom % 3) != 0), "R3 random");
        end

        // reset from complete
        send(1'b0, "R3 pre"); send(1'b1, "R3 pre"); send(1'b1, "R2 pre");
        do_reset();
        summary();
    end

endmodule